// File: doc/BRIEF.md
# Half-Duplex Clocked Programming Link Engine

This block is the host end of a two-wire serial link used to program small microcontrollers. One wire carries a link clock that the host generates. The other is a shared data wire that the host either drives or releases. A third output holds the target in reset for the whole programming session. All three wires are presented as a value plus an output enable, so that the pad ring can build the tristate buffers.

Software or a higher-level sequencer gives the block one of four commands over a valid/ready handshake: open a session, close a session, transmit a byte, or receive a byte. Every byte travels in a fixed 12-bit frame:

- one low start bit;
- eight data bits, least-significant bit first;
- an even-parity bit;
- two high stop bits.

Transmitted bits change when the link clock falls. Received bits are sampled when it rises. The engine turns the data wire around between the two directions on its own. It also reports every received byte with a one-cycle strobe and an error flag.

Top module: `pgm_link_engine`

## Requirements
- R1: A transmitted frame is 12 bit times long. Bit 0 is a low start bit, bits 1 to 8 carry the byte least-significant bit first, bit 9 is parity, and bits 10 and 11 are high.
- R2: The parity bit makes the count of ones across the eight data bits and the parity bit even.
- R3: While the engine drives the data wire, the wire changes value only in the cycle where the link clock falls.
- R4: A receive samples the wire only on rising link-clock edges. Rising edges that find the wire high are skipped. The first low sample is the start bit and is dropped, and the following eight samples form `rx_data` with the least-significant bit first.
- R5: Opening a session (op code 0) drives `tgt_rst_oe` high with `tgt_rst_n_o` low at once. The clock and data drivers are enabled only RST_HOLD system cycles later. The reset stays driven low for as long as the link clock is driven.
- R6: After the reset hold, the engine drives the data wire high for two break frames (24 falling link-clock edges) before `cmd_ready` returns.
- R7: Closing a session (op code 1) removes all three output enables. At reset the engine is in the same closed state.
- R8: Turnaround from transmit to receive releases the data wire on a falling clock edge, only after the last frame's final stop bit has been held for a full bit time. Turnaround from receive to transmit drives the wire high for at least one rising edge before the start bit.
- R9: A transmit frame (op code 2) is loaded only after the previous frame has shifted out completely. `cmd_ready` stays low for exactly 12 falling link-clock edges after a byte is accepted in transmit mode.
- R10: `rx_err` is raised together with `rx_valid` when the received parity is wrong or either stop bit is low.
- R11: While a session is open, the link clock toggles without pause every HALF_DIV system cycles, including between frames.
- R12: While closed, `cmd_ready` is high. Transmit and receive commands (op codes 2 and 3) are accepted and have no effect: no wire is driven and no byte is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 2 | 0 open, 1 close, 2 transmit, 3 receive |
| cmd_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_err | output | 1 | Parity or stop-bit error on the received frame |
| link_clk_o | output | 1 | Link clock value |
| link_clk_oe | output | 1 | Link clock driver enable |
| link_dat_o | output | 1 | Data wire value when driven |
| link_dat_oe | output | 1 | Data wire driver enable |
| link_dat_i | input | 1 | Data wire as seen at the pad |
| tgt_rst_n_o | output | 1 | Target reset value (active low) |
| tgt_rst_oe | output | 1 | Target reset driver enable |

## Verification
The hardest case to reach is the receive start search. The engine is released onto a wire that the target keeps high for an unknown number of bit times, and the first low sample must then be taken as the start bit without slipping a bit. The bench plays the target. It waits until the data enable drops, idles the wire high for a random number of link-clock falls (up to twenty in a directed case), and then drives a frame. Some frames carry a deliberately broken parity or stop bit. Transmit and receive commands are mixed at random, so that both turnaround directions occur repeatedly.

// File: rtl/pgm_link_pkg.sv
package pgm_link_pkg;

  localparam int FRAME_BITS = 12;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_CLOSE = 2'd1,
    OP_SEND  = 2'd2,
    OP_RECV  = 2'd3
  } link_op_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_HOLD, ST_BRK, ST_IDLE, ST_TX, ST_TURN_RX, ST_RX, ST_TURN_TX
  } link_st_e;

  localparam logic [FRAME_BITS-1:0] BREAK_FRAME = '1;

  // Parity bit that makes byte plus parity carry an even count of ones.
  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

  // Frame in shift order: bit 0 leaves first.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
    return {2'b11, even_par(b), b, 1'b0};
  endfunction

  // Received word without start bit: [7:0] data, [8] parity, [10:9] stops.
  function automatic logic frame_bad(input logic [FRAME_BITS-2:0] w);
    return (even_par(w[7:0]) != w[8]) | ~w[9] | ~w[10];
  endfunction

endpackage

// File: rtl/pgm_link_clkgen.sv
module pgm_link_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic link_clk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt;
  logic          clk_q;
  logic          tick;

  assign tick     = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_evt = tick && !clk_q;
  assign fall_evt = tick && clk_q;
  assign link_clk = clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R11: a toggle of the running link clock only ends a full half period
  a_r11_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && (clk_q != $past(clk_q))) |-> ($past(cnt) == CW'(HALF_DIV - 1)));

endmodule

// File: rtl/pgm_link_shifter.sv
module pgm_link_shifter
  import pgm_link_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_load,
  input  logic [FRAME_BITS-1:0] tx_frame,
  input  logic                  rx_start,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  din,
  output logic                  dout,
  output logic                  busy,
  output logic                  rx_done,
  output logic [FRAME_BITS-2:0] rx_word
);
  localparam int BW = $clog2(FRAME_BITS + 1);

  logic [BW-1:0]         bits_left;
  logic                  mode_rx;
  logic                  hunt;
  logic [FRAME_BITS-1:0] sr;
  logic                  dout_q;
  logic                  done_q;

  assign dout    = dout_q;
  assign busy    = (bits_left != '0) || hunt;
  assign rx_done = done_q;
  assign rx_word = sr[FRAME_BITS-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_left <= '0;
      mode_rx   <= 1'b0;
      hunt      <= 1'b0;
      sr        <= '1;
      dout_q    <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tx_load) begin
        sr        <= tx_frame;
        bits_left <= BW'(FRAME_BITS);
        mode_rx   <= 1'b0;
        hunt      <= 1'b0;
      end else if (rx_start) begin
        mode_rx   <= 1'b1;
        hunt      <= 1'b1;
        bits_left <= '0;
      end else if (!mode_rx) begin
        if (fall_evt && bits_left != '0) begin
          dout_q    <= sr[0];
          sr        <= {1'b1, sr[FRAME_BITS-1:1]};
          bits_left <= bits_left - 1'b1;
        end
      end else if (rise_evt) begin
        if (hunt) begin
          if (!din) begin
            hunt      <= 1'b0;
            bits_left <= BW'(FRAME_BITS - 1);
          end
        end else if (bits_left != '0) begin
          sr        <= {din, sr[FRAME_BITS-1:1]};
          bits_left <= bits_left - 1'b1;
          if (bits_left == BW'(1)) done_q <= 1'b1;
        end
      end
    end
  end

  // R3: the transmit bit changes only in a falling-edge cycle
  a_r3_tx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rx && !$past(mode_rx) && (dout_q != $past(dout_q))) |-> $past(fall_evt));

  // R4: the receive register moves only in a rising-edge cycle
  a_r4_rx_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rx && $past(mode_rx) && (sr != $past(sr))) |-> $past(rise_evt));

  // R9: a new frame never overwrites one still shifting
  a_r9_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (bits_left == '0 && !hunt));

endmodule

// File: rtl/pgm_link_engine.sv
module pgm_link_engine
  import pgm_link_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int RST_HOLD = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_err,
  output logic       link_clk_o,
  output logic       link_clk_oe,
  output logic       link_dat_o,
  output logic       link_dat_oe,
  input  logic       link_dat_i,
  output logic       tgt_rst_n_o,
  output logic       tgt_rst_oe
);
  localparam int HW = $clog2(RST_HOLD + 1);

  link_st_e              st;
  logic [HW-1:0]         hold_cnt;
  logic [1:0]            brk_left;
  logic                  sending;
  logic [7:0]            pend;
  logic                  clk_en;
  logic                  dat_oe_q;
  logic                  rst_oe_q;

  logic                  acc;
  link_op_e              op;
  logic                  tx_load;
  logic                  rx_start;
  logic [FRAME_BITS-1:0] frame;
  logic                  rise_evt;
  logic                  fall_evt;
  logic                  sh_busy;
  logic                  sh_done;
  logic [FRAME_BITS-2:0] sh_word;
  logic                  sh_dout;

  pgm_link_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (clk_en),
    .link_clk (link_clk_o),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pgm_link_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_load  (tx_load),
    .tx_frame (frame),
    .rx_start (rx_start),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .din      (link_dat_i),
    .dout     (sh_dout),
    .busy     (sh_busy),
    .rx_done  (sh_done),
    .rx_word  (sh_word)
  );

  assign cmd_ready   = (st == ST_OFF) || (st == ST_IDLE);
  assign acc         = cmd_valid && cmd_ready;
  assign op          = link_op_e'(cmd_op);
  assign link_clk_oe = clk_en;
  assign link_dat_oe = dat_oe_q;
  assign link_dat_o  = sh_dout;
  assign tgt_rst_oe  = rst_oe_q;
  assign tgt_rst_n_o = 1'b0;
  assign rx_valid    = sh_done;
  assign rx_data     = sh_word[7:0];
  assign rx_err      = sh_done && frame_bad(sh_word);

  always_comb begin
    tx_load  = 1'b0;
    rx_start = 1'b0;
    frame    = BREAK_FRAME;
    unique case (st)
      ST_BRK: begin
        if (!sh_busy && brk_left != 2'd0) tx_load = 1'b1;
      end
      ST_IDLE: begin
        if (acc && op == OP_SEND && sending) begin
          tx_load = 1'b1;
          frame   = build_frame(cmd_data);
        end
        if (acc && op == OP_RECV && !sending) rx_start = 1'b1;
      end
      ST_TURN_TX: begin
        if (rise_evt) begin
          tx_load = 1'b1;
          frame   = build_frame(pend);
        end
      end
      ST_TURN_RX: begin
        if (fall_evt) rx_start = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      hold_cnt <= '0;
      brk_left <= 2'd0;
      sending  <= 1'b0;
      pend     <= '0;
      clk_en   <= 1'b0;
      dat_oe_q <= 1'b0;
      rst_oe_q <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: begin
          if (acc && op == OP_OPEN) begin
            rst_oe_q <= 1'b1;
            hold_cnt <= '0;
            st       <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          hold_cnt <= hold_cnt + 1'b1;
          if (hold_cnt == HW'(RST_HOLD - 1)) begin
            clk_en   <= 1'b1;
            dat_oe_q <= 1'b1;
            sending  <= 1'b1;
            brk_left <= 2'd2;
            st       <= ST_BRK;
          end
        end
        ST_BRK: begin
          if (!sh_busy) begin
            if (brk_left != 2'd0) brk_left <= brk_left - 1'b1;
            else                  st       <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (acc) begin
            unique case (op)
              OP_CLOSE: begin
                clk_en   <= 1'b0;
                dat_oe_q <= 1'b0;
                rst_oe_q <= 1'b0;
                sending  <= 1'b0;
                st       <= ST_OFF;
              end
              OP_SEND: begin
                if (sending) begin
                  st <= ST_TX;
                end else begin
                  dat_oe_q <= 1'b1;
                  sending  <= 1'b1;
                  pend     <= cmd_data;
                  st       <= ST_TURN_TX;
                end
              end
              OP_RECV: begin
                st <= sending ? ST_TURN_RX : ST_RX;
              end
              default: ;
            endcase
          end
        end
        ST_TX: begin
          if (!sh_busy) st <= ST_IDLE;
        end
        ST_TURN_TX: begin
          if (rise_evt) st <= ST_TX;
        end
        ST_TURN_RX: begin
          if (fall_evt) begin
            dat_oe_q <= 1'b0;
            sending  <= 1'b0;
            st       <= ST_RX;
          end
        end
        ST_RX: begin
          if (sh_done) st <= ST_IDLE;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  // R5: whenever the link clock is driven, the target is held in reset
  a_r5_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
    link_clk_oe |-> (tgt_rst_oe && !tgt_rst_n_o));

  // R7: the closed state drives none of the three wires
  a_r7_closed_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF) |-> !(link_clk_oe || link_dat_oe || tgt_rst_oe));

  // R8: the data wire is given up on a falling edge with no frame in flight
  a_r8_release_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(link_dat_oe) && link_clk_oe) |-> ($past(fall_evt) && !$past(sh_busy)));

  // R6: no command is taken while break frames are being sent
  a_r6_no_cmd_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_BRK) && sh_busy) |-> !cmd_ready);

endmodule

// File: tb/pgm_link_engine_tb.sv
`timescale 1ns/1ps
module pgm_link_engine_tb;
  import pgm_link_pkg::*;

  localparam int HD = 4;
  localparam int RH = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic rx_valid, rx_err;
  logic [7:0] rx_data;
  logic link_clk_o, link_clk_oe, link_dat_o, link_dat_oe, link_dat_i;
  logic tgt_rst_n_o, tgt_rst_oe;
  logic tgt_drv_en = 1'b0;
  logic tgt_bit = 1'b1;

  always #2.5 clk = ~clk;

  assign link_dat_i = link_dat_oe ? link_dat_o : (tgt_drv_en ? tgt_bit : 1'b1);

  pgm_link_engine #(.HALF_DIV(HD), .RST_HOLD(RH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .link_clk_o(link_clk_o), .link_clk_oe(link_clk_oe),
    .link_dat_o(link_dat_o), .link_dat_oe(link_dat_oe), .link_dat_i(link_dat_i),
    .tgt_rst_n_o(tgt_rst_n_o), .tgt_rst_oe(tgt_rst_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  int frames = 0;
  bit tb_sending = 0;
  bit got_rx = 0;
  logic [7:0] got_data;
  logic got_err;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic bench_par(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (b[i]) n++;
    return (n % 2) == 1;
  endfunction

  // Line monitor and frame decoder (samples away from the active edge)
  logic lprev = 1'b0;
  logic p_oe = 1'b0;
  logic p_dat = 1'b1;
  bit in_frame = 0;
  int nb = 0;
  logic [10:0] fr;
  bit last_hi = 0;
  always @(negedge clk) begin
    bit lrise, lfall;
    lrise = link_clk_oe && link_clk_o && !lprev;
    lfall = !link_clk_o && lprev;
    if (rst_n) begin
      if (link_dat_oe && p_oe && link_dat_o != p_dat)
        chk(lfall, "R3 data moved off a falling edge", int'(link_clk_o), 0);
      if (p_oe && !link_dat_oe && link_clk_oe)
        chk(lfall && !in_frame, "R8 release point", int'(in_frame), 0);
      if (lrise) begin
        chk(tgt_rst_oe && !tgt_rst_n_o, "R5 reset held in session", int'(tgt_rst_oe), 1);
        if (link_dat_oe) begin
          if (!in_frame) begin
            if (!link_dat_o) begin
              chk(last_hi, "R8 wire high before start bit", int'(last_hi), 1);
              in_frame = 1;
              nb = 0;
            end
          end else begin
            fr[nb] = link_dat_o;
            nb++;
            if (nb == 11) begin
              in_frame = 0;
              frames++;
              if (exp_q.size() == 0) begin
                chk(0, "R1 unexpected frame", int'(fr[7:0]), 0);
              end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(fr[7:0] == e, "R1 data bits", int'(fr[7:0]), int'(e));
                chk(fr[8] == bench_par(e), "R2 parity", int'(fr[8]), int'(bench_par(e)));
                chk(fr[10:9] == 2'b11, "R1 stop bits", int'(fr[10:9]), 3);
              end
            end
          end
        end
        last_hi = link_dat_oe && link_dat_o;
      end
      if (rx_valid) begin
        got_rx = 1;
        got_data = rx_data;
        got_err = rx_err;
      end
    end
    lprev = link_clk_o;
    p_oe = link_dat_oe;
    p_dat = link_dat_o;
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic issue(input link_op_e op, input logic [7:0] d);
    @(negedge clk);
    cmd_op = op;
    cmd_data = d;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_lfall();
    logic p;
    p = link_clk_o;
    forever begin
      @(negedge clk);
      if (p && !link_clk_o) break;
      p = link_clk_o;
    end
  endtask

  task automatic do_open();
    int n;
    int nf;
    bit hi_ok;
    issue(OP_OPEN, 8'h00);
    chk(tgt_rst_oe && !tgt_rst_n_o && !link_clk_oe && !link_dat_oe, "R5 reset before link",
        int'({tgt_rst_oe, link_clk_oe, link_dat_oe}), 4);
    n = 0;
    while (!link_clk_oe) begin
      @(negedge clk);
      n++;
    end
    chk(n >= RH, "R5 reset hold cycles", n, RH);
    nf = 0;
    hi_ok = 1;
    begin
      logic p;
      p = link_clk_o;
      while (!cmd_ready) begin
        @(negedge clk);
        if (!(link_dat_oe && link_dat_o)) hi_ok = 0;
        if (p && !link_clk_o) nf++;
        p = link_clk_o;
      end
    end
    chk(nf >= 24 && nf <= 25, "R6 break length in falls", nf, 24);
    chk(hi_ok, "R6 wire high during breaks", int'(hi_ok), 1);
    tb_sending = 1;
  endtask

  task automatic do_send(input logic [7:0] b);
    bit was;
    int nf;
    was = tb_sending;
    exp_q.push_back(b);
    issue(OP_SEND, b);
    tb_sending = 1;
    if (was) begin
      logic p;
      nf = 0;
      p = link_clk_o;
      while (!cmd_ready) begin
        @(negedge clk);
        if (p && !link_clk_o) nf++;
        p = link_clk_o;
      end
      chk(nf == 12, "R9 frame occupancy in falls", nf, 12);
    end else begin
      while (!cmd_ready) @(negedge clk);
    end
  endtask

  // mode: 0 clean, 1 parity flipped, 2 first stop low, 3 second stop low
  task automatic do_recv(input logic [7:0] b, input int mode, input int k);
    logic [11:0] f;
    got_rx = 0;
    issue(OP_RECV, 8'h00);
    tb_sending = 0;
    while (link_dat_oe) @(negedge clk);
    tgt_bit = 1'b1;
    tgt_drv_en = 1'b1;
    repeat (k) wait_lfall();
    f[0] = 1'b0;
    f[8:1] = b;
    f[9] = bench_par(b) ^ (mode == 1);
    f[10] = (mode != 2);
    f[11] = (mode != 3);
    for (int i = 0; i < 12; i++) begin
      wait_lfall();
      tgt_bit = f[i];
    end
    wait_lfall();
    tgt_bit = 1'b1;
    tgt_drv_en = 1'b0;
    while (!got_rx) @(negedge clk);
    chk(got_data == b, "R4 received byte", int'(got_data), int'(b));
    chk(got_err == (mode != 0), "R10 error flag", int'(got_err), int'(mode != 0));
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!link_clk_oe && !link_dat_oe && !tgt_rst_oe, "R7 reset state released",
        int'({link_clk_oe, link_dat_oe, tgt_rst_oe}), 0);
    chk(cmd_ready && !rx_valid, "R12 ready while closed", int'(cmd_ready), 1);

    // R12: transmit and receive while closed have no effect
    issue(OP_SEND, 8'h5A);
    repeat (100) @(negedge clk);
    chk(!link_dat_oe && !link_clk_oe && frames == 0, "R12 send ignored when closed",
        int'(link_dat_oe), 0);
    got_rx = 0;
    issue(OP_RECV, 8'h00);
    repeat (100) @(negedge clk);
    chk(!got_rx && !tgt_rst_oe && cmd_ready, "R12 receive ignored when closed", int'(got_rx), 0);

    do_open();

    // R11: half period of the free-running link clock
    begin
      logic p;
      p = link_clk_o;
      while (link_clk_o == p) @(negedge clk);
      p = link_clk_o;
      n = 0;
      while (link_clk_o == p) begin
        @(negedge clk);
        n++;
      end
      chk(n == HD, "R11 half period", n, HD);
      repeat (5 * HD) @(negedge clk);
      chk(link_clk_oe, "R11 clock driven while idle", int'(link_clk_oe), 1);
    end

    do_send(8'h00);
    do_send(8'hFF);
    do_send(8'h01);
    do_send(8'h80);
    do_send(8'hA5);
    do_recv(8'h3C, 0, 2);
    do_recv(8'hC3, 0, 20);
    do_recv(8'h11, 1, 1);
    do_recv(8'h22, 2, 1);
    do_recv(8'h44, 3, 3);
    do_send(8'h7E);
    do_send(8'h81);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if ($urandom % 2 == 0) do_send(b);
      else do_recv(b, ($urandom % 4 == 0) ? int'(1 + $urandom % 3) : 0, int'(1 + $urandom % 6));
    end

    // R7: close the session
    issue(OP_CLOSE, 8'h00);
    @(negedge clk);
    chk(!link_clk_oe && !link_dat_oe && !tgt_rst_oe, "R7 close releases wires",
        int'({link_clk_oe, link_dat_oe, tgt_rst_oe}), 0);
    begin
      logic p;
      bit steady;
      p = link_clk_o;
      steady = 1;
      repeat (4 * HD) begin
        @(negedge clk);
        if (link_clk_o != p) steady = 0;
      end
      chk(steady, "R7 clock stopped after close", int'(steady), 1);
    end
    tb_sending = 0;

    do_open();
    do_send(8'h5A);
    do_recv(8'hA5, 0, 2);
    do_send(8'h3F);
    repeat (4 * HD) @(negedge clk);
    chk(exp_q.size() == 0, "R1 every sent byte framed", exp_q.size(), 0);

    finish_run();
  end

endmodule